// File: doc/BRIEF.md
# Embedded Controller Host Port

This block is the device side of a two-port host channel into a small internal register space. The host sees one data port and one port that reads as status and takes command bytes when written. The host never addresses a register directly. It writes a command byte, then a register address, and for a write a value byte. The block turns each finished sequence into a single strobe on an internal register-file port.

Two handshake flags in the status byte pace the host. The input-full flag stays set for a configurable number of cycles after each accepted host byte, which models the time the controller needs to consume it. The output-full flag is set when a fetched register value waits in the data port, and it clears when the host reads that port. A command flag records whether the last accepted byte went to the command port. A burst flag can be set and cleared by command and is only reported. Bytes that do not fit the current sequence are dropped. A new command cancels any sequence that is partly collected.

Top module: `ec_host_port`

## Requirements
- R1: After a synchronous active-low reset, the status byte reads 0x00 and neither register-file strobe (`rf_re`, `rf_we`) is asserted.
- R2: Host offset 0 is the data port and offset 4 is the status/command port. A read of any other offset returns 0x00, and a write to it is ignored: it leaves the input-full flag clear and causes no strobe. Status bits 7, 6, 5 and 2 always read 0.
- R3: Status bit 1 (input full) is 1 for exactly `IBF_LAT` cycles after each accepted host write. A write accepted while the flag is set restarts the full count.
- R4: Status bit 3 is 1 after a byte is accepted at the command port and 0 after a byte is accepted at the data port.
- R5: Command 0x80 followed by an address byte drives `rf_re` for one cycle with `rf_addr` equal to that byte, in the cycle after the address write. The register file answers one cycle later. The value then appears in the data port, with status bit 0 (output full) set, after the third clock edge counted from the address write.
- R6: A host read of the data port clears status bit 0. A read of the status port leaves it unchanged.
- R7: Command 0x81, then an address byte, then a value byte drives `rf_we` for exactly one cycle, with that address and value, in the cycle after the value write.
- R8: Command 0x82 sets status bit 4 and command 0x83 clears it.
- R9: An unrecognised command byte returns the sequencer to idle. A data byte that arrives with no command pending is dropped. Neither case produces a strobe.
- R10: A command written while an earlier sequence is still collecting bytes cancels that sequence. The earlier sequence produces no strobe, and the new command runs normally.
- R11: When a fetched value lands in the same cycle that the host reads the data port, the output-full flag stays set and the data port holds the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_addr | input | ADDR_W | Host port offset |
| host_wr | input | 1 | Host write strobe, one byte per cycle |
| host_rd | input | 1 | Host read strobe, one byte per cycle |
| host_wdata | input | 8 | Byte written by the host |
| host_rdata | output | 8 | Byte presented to the host for the current offset |
| rf_addr | output | RF_AW | Register-file address |
| rf_re | output | 1 | Register-file read strobe, data expected one cycle later |
| rf_we | output | 1 | Register-file write strobe |
| rf_wdata | output | 8 | Register-file write value |
| rf_rdata | input | 8 | Register-file read value |

## Verification
Two pairs of events can fall on the same clock edge. In the first, a fetched register value lands in the data port while the host reads that port. The bench schedules the data-port read so that its strobe is sampled on the capture edge. It then expects the output-full flag to stay set, and the following read to return the fetched value. In the second, a host write arrives while the input-full countdown is still running. The bench writes twice, two cycles apart, and counts the cycles until the flag drops, which must be the full latency measured from the second write.

// File: rtl/ec_host_pkg.sv
// ec_host_pkg: command codes, sequencer states and status bit positions
// shared by the host port modules. Assumes byte-wide host data.
package ec_host_pkg;
    localparam logic [7:0] CMD_RD_REG  = 8'h80;
    localparam logic [7:0] CMD_WR_REG  = 8'h81;
    localparam logic [7:0] CMD_BURST_ON  = 8'h82;
    localparam logic [7:0] CMD_BURST_OFF = 8'h83;

    localparam int ST_OUT_FULL = 0;
    localparam int ST_IN_FULL  = 1;
    localparam int ST_CMD_LAST = 3;
    localparam int ST_BURST    = 4;

    typedef enum logic [1:0] {
        SEQ_IDLE    = 2'd0,
        SEQ_RD_ADDR = 2'd1,
        SEQ_WR_ADDR = 2'd2,
        SEQ_WR_VAL  = 2'd3
    } seq_state_t;
endpackage

// File: rtl/ec_ibf_timer.sv
// ec_ibf_timer: keeps the input-full flag high for LAT cycles after each
// load pulse. Assumes LAT >= 1. A load while counting restarts the count.
module ec_ibf_timer #(
    parameter int LAT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic busy
);
    localparam int CNT_W = $clog2(LAT + 1);

    logic [CNT_W-1:0] cnt;

    // Countdown of remaining consume-latency cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= CNT_W'(LAT);
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign busy = (cnt != '0);

    assert_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt == CNT_W'(LAT)));
    assert_countdown_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt != '0) |=> (cnt == CNT_W'($past(cnt) - 1'b1)));
endmodule

// File: rtl/ec_cmd_seq.sv
// ec_cmd_seq: collects command, address and value bytes and issues one
// register-file strobe per completed sequence. Assumes at most one of
// cmd_wr / dat_wr per cycle, and RF_AW <= 8.
module ec_cmd_seq
    import ec_host_pkg::*;
#(
    parameter int RF_AW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_wr,
    input  logic             dat_wr,
    input  logic [7:0]       wbyte,
    output logic [RF_AW-1:0] rf_addr,
    output logic             rf_re,
    output logic             rf_we,
    output logic [7:0]       rf_wdata,
    output logic             burst
);
    seq_state_t state;

    // Sequencer: commands restart it, data bytes advance it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= SEQ_IDLE;
            rf_addr  <= '0;
            rf_re    <= 1'b0;
            rf_we    <= 1'b0;
            rf_wdata <= '0;
            burst    <= 1'b0;
        end else begin
            rf_re <= 1'b0;
            rf_we <= 1'b0;
            if (cmd_wr) begin
                case (wbyte)
                    CMD_RD_REG:    state <= SEQ_RD_ADDR;
                    CMD_WR_REG:    state <= SEQ_WR_ADDR;
                    CMD_BURST_ON:  begin burst <= 1'b1; state <= SEQ_IDLE; end
                    CMD_BURST_OFF: begin burst <= 1'b0; state <= SEQ_IDLE; end
                    default:       state <= SEQ_IDLE;
                endcase
            end else if (dat_wr) begin
                case (state)
                    SEQ_RD_ADDR: begin
                        rf_re   <= 1'b1;
                        rf_addr <= wbyte[RF_AW-1:0];
                        state   <= SEQ_IDLE;
                    end
                    SEQ_WR_ADDR: begin
                        rf_addr <= wbyte[RF_AW-1:0];
                        state   <= SEQ_WR_VAL;
                    end
                    SEQ_WR_VAL: begin
                        rf_we    <= 1'b1;
                        rf_wdata <= wbyte;
                        state    <= SEQ_IDLE;
                    end
                    default: state <= SEQ_IDLE;
                endcase
            end
        end
    end

    assert_single_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rf_re, rf_we}));
    assert_write_needs_byte_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> $past(dat_wr));
    assert_burst_on_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && wbyte == CMD_BURST_ON) |=> burst);
    assert_burst_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && wbyte == CMD_BURST_OFF) |=> !burst);
    assert_cmd_aborts_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr |=> (!rf_re && !rf_we));
endmodule

// File: rtl/ec_host_port.sv
// ec_host_port: host-facing data and status/command ports over an internal
// register file. Assumes a register file with one cycle of read latency and
// a host that sends at most one strobe per cycle.
module ec_host_port
    import ec_host_pkg::*;
#(
    parameter int ADDR_W   = 3,
    parameter int RF_AW    = 8,
    parameter int IBF_LAT  = 4,
    parameter int DATA_OFS = 0,
    parameter int CMD_OFS  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [7:0]        host_wdata,
    output logic [7:0]        host_rdata,
    output logic [RF_AW-1:0]  rf_addr,
    output logic              rf_re,
    output logic              rf_we,
    output logic [7:0]        rf_wdata,
    input  logic [7:0]        rf_rdata
);
    localparam logic [ADDR_W-1:0] DAT_A = ADDR_W'(DATA_OFS);
    localparam logic [ADDR_W-1:0] CMD_A = ADDR_W'(CMD_OFS);

    logic       hit_dat, hit_cmd, cmd_wr, dat_wr, dat_rd;
    logic       ibf, obf, cmd_last, burst, cap_pend;
    logic [7:0] out_q, status;

    assign hit_dat = (host_addr == DAT_A);
    assign hit_cmd = (host_addr == CMD_A);
    assign cmd_wr  = host_wr && hit_cmd;
    assign dat_wr  = host_wr && hit_dat;
    assign dat_rd  = host_rd && hit_dat;

    ec_ibf_timer #(.LAT(IBF_LAT)) u_ibf (
        .clk  (clk),
        .rst_n(rst_n),
        .load (cmd_wr || dat_wr),
        .busy (ibf)
    );

    ec_cmd_seq #(.RF_AW(RF_AW)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmd_wr  (cmd_wr),
        .dat_wr  (dat_wr),
        .wbyte   (host_wdata),
        .rf_addr (rf_addr),
        .rf_re   (rf_re),
        .rf_we   (rf_we),
        .rf_wdata(rf_wdata),
        .burst   (burst)
    );

    // Output path: capture the fetched value, pace with output-full.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_pend <= 1'b0;
            out_q    <= '0;
            obf      <= 1'b0;
        end else begin
            cap_pend <= rf_re;
            if (cap_pend) begin
                out_q <= rf_rdata;
                obf   <= 1'b1;
            end else if (dat_rd) begin
                obf <= 1'b0;
            end
        end
    end

    // Command flag: which port took the last accepted byte.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cmd_last <= 1'b0;
        else if (cmd_wr)
            cmd_last <= 1'b1;
        else if (dat_wr)
            cmd_last <= 1'b0;
    end

    // Status byte assembly and host read mux.
    always_comb begin
        status = '0;
        status[ST_OUT_FULL] = obf;
        status[ST_IN_FULL]  = ibf;
        status[ST_CMD_LAST] = cmd_last;
        status[ST_BURST]    = burst;
        if (hit_dat)
            host_rdata = out_q;
        else if (hit_cmd)
            host_rdata = status;
        else
            host_rdata = '0;
    end

    assert_obf_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_rd && !cap_pend) |=> !obf);
    assert_capture_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cap_pend |=> obf);
    assert_cmd_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr |=> cmd_last);
    assert_stray_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && !hit_dat && !hit_cmd && !ibf) |=> !ibf);
    assert_fetch_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rf_re |=> cap_pend);
endmodule

// File: tb/ec_host_port_bench.sv
module ec_host_port_bench;
    localparam int LAT = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] host_addr = '0;
    logic       host_wr = 1'b0;
    logic       host_rd = 1'b0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic [7:0] rf_addr;
    logic       rf_re, rf_we;
    logic [7:0] rf_wdata;
    logic [7:0] rf_rdata = '0;

    int checks = 0;
    int fails  = 0;
    int we_cnt = 0;
    int re_cnt = 0;
    logic [7:0] mem [256];

    always #10 clk = ~clk;

    ec_host_port #(.IBF_LAT(LAT)) u_ec_host_port (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
        .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .rf_addr(rf_addr), .rf_re(rf_re), .rf_we(rf_we),
        .rf_wdata(rf_wdata), .rf_rdata(rf_rdata)
    );

    // Register-file model with one cycle of read latency.
    always @(posedge clk) begin
        if (rf_we) begin mem[rf_addr] <= rf_wdata; we_cnt++; end
        if (rf_re) begin rf_rdata <= mem[rf_addr]; re_cnt++; end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic peek(input logic [2:0] a, output logic [7:0] v);
        host_addr = a;
        #1 v = host_rdata;
    endtask

    task automatic hwr(input logic [2:0] a, input logic [7:0] d);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic hrd(input logic [2:0] a, output logic [7:0] v);
        host_addr = a; host_rd = 1'b1;
        #1 v = host_rdata;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic wait_ibf;
        logic [7:0] s;
        peek(3'd4, s);
        while (s[1]) begin @(negedge clk); peek(3'd4, s); end
    endtask

    task automatic ec_write(input logic [7:0] a, input logic [7:0] d);
        wait_ibf; hwr(3'd4, 8'h81);
        wait_ibf; hwr(3'd0, a);
        wait_ibf; hwr(3'd0, d);
        chk("R7 rf_we", rf_we, 1);
        chk("R7 rf_addr", rf_addr, a);
        chk("R7 rf_wdata", rf_wdata, d);
    endtask

    task automatic ec_read(input logic [7:0] a, output logic [7:0] v);
        logic [7:0] s;
        wait_ibf; hwr(3'd4, 8'h80);
        wait_ibf; hwr(3'd0, a);
        chk("R5 rf_re", rf_re, 1);
        chk("R5 rf_addr", rf_addr, a);
        @(negedge clk); peek(3'd4, s);
        chk("R5 obf early", s[0], 0);
        @(negedge clk); peek(3'd4, s);
        chk("R5 obf set", s[0], 1);
        hrd(3'd0, v);
        peek(3'd4, s);
        chk("R6 obf cleared", s[0], 0);
    endtask

    initial begin
        #(20 * 150000);
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] s, v;
        int w0, r0, n;
        for (int i = 0; i < 256; i++) mem[i] = 8'(i ^ 8'h5A);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        peek(3'd4, s);
        chk("R1 status", s, 0);
        chk("R1 strobes", {rf_re, rf_we}, 0);

        // R2: other offsets
        peek(3'd2, s); chk("R2 offset2 read", s, 0);
        w0 = we_cnt; r0 = re_cnt;
        hwr(3'd1, 8'h80);
        peek(3'd4, s); chk("R2 stray write ibf", s, 0);
        hwr(3'd1, 8'h11);
        @(negedge clk);
        chk("R2 no strobe", (we_cnt - w0) + (re_cnt - r0), 0);

        // R3: exact latency, then restart
        hwr(3'd4, 8'h83);
        n = 0; peek(3'd4, s);
        while (s[1] && n < 20) begin n++; @(negedge clk); peek(3'd4, s); end
        chk("R3 ibf cycles", n, LAT);
        hwr(3'd4, 8'h83);
        @(negedge clk); @(negedge clk);
        hwr(3'd4, 8'h83);
        n = 0; peek(3'd4, s);
        while (s[1] && n < 20) begin n++; @(negedge clk); peek(3'd4, s); end
        chk("R3 restart cycles", n, LAT);

        // R4 and R8
        hwr(3'd4, 8'h82); wait_ibf; peek(3'd4, s);
        chk("R4 cmd flag set", s[3], 1);
        chk("R8 burst on", s[4], 1);
        chk("R2 reserved bits", s & 8'hE4, 0);
        hwr(3'd0, 8'h33); wait_ibf; peek(3'd4, s);
        chk("R4 cmd flag clear", s[3], 0);
        hwr(3'd4, 8'h83); wait_ibf; peek(3'd4, s);
        chk("R8 burst off", s[4], 0);

        // R9: unknown command then data; orphan data
        w0 = we_cnt; r0 = re_cnt;
        hwr(3'd4, 8'h55); wait_ibf;
        hwr(3'd0, 8'h10); wait_ibf;
        hwr(3'd0, 8'h20); wait_ibf;
        hwr(3'd0, 8'h30); wait_ibf;
        @(negedge clk);
        chk("R9 dropped", (we_cnt - w0) + (re_cnt - r0), 0);

        // R10: write aborted by read
        w0 = we_cnt;
        hwr(3'd4, 8'h81); wait_ibf;
        hwr(3'd0, 8'h05); wait_ibf;
        ec_read(8'h09, v);
        chk("R10 no write", we_cnt - w0, 0);
        chk("R10 read value", v, 8'h09 ^ 8'h5A);
        // R10: read aborted by write
        r0 = re_cnt;
        hwr(3'd4, 8'h80); wait_ibf;
        ec_write(8'h07, 8'hC3);
        @(negedge clk);
        chk("R10 no read", re_cnt - r0, 0);
        chk("R10 write landed", mem[7], 8'hC3);

        // R11: capture coincides with host data read
        wait_ibf; hwr(3'd4, 8'h80);
        wait_ibf; hwr(3'd0, 8'h07);
        @(negedge clk);
        hrd(3'd0, v);
        peek(3'd4, s);
        chk("R11 obf kept", s[0], 1);
        hrd(3'd0, v);
        chk("R11 new value", v, 8'hC3);

        // R5/R7 sweep across the whole register space
        for (int a = 0; a < 256; a++) ec_write(8'(a), 8'((a * 13 + 5) & 255));
        for (int a = 0; a < 256; a++) begin
            ec_read(8'(a), v);
            chk("R5 sweep value", v, (a * 13 + 5) & 255);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule